// File: doc/BRIEF.md
# Ethernet DMA Status and Interrupt Register Bank

This block is the register bank of an Ethernet DMA controller. Software reaches it through a plain read/write strobe port with a byte address. Inside it holds the DMA status word, the interrupt mask, the control and bus-mode words, and the base and current descriptor pointers of the two rings. Words in the window that have no special behaviour are kept in a block-RAM-friendly store.

The transmit and receive descriptor engines sit next to the bank. They send single-cycle event pulses, which set status bits, and pointer-advance requests, which move the current descriptor pointers. The bank gives the engines the current pointers, a receive-enable level and a one-cycle transmit poll pulse. A single registered interrupt line is high whenever an enabled status bit is set. Software clears status bits by writing ones to them.

Top module: `dmareg_bank`

## Requirements
- R1: The word index is the byte address shifted right by 2. Status is at word 0x3C5, control at word 0x3C6 and interrupt mask at word 0x3C7. A read strobe returns the word on `reg_rdata` with `reg_rvalid` high one cycle later.
- R2: A write to the status word clears every status bit that is 1 in the written data and leaves the other status bits unchanged.
- R3: A transmit-done pulse sets status bits 0 and 16. A receive-done pulse sets bits 6 and 16. A no-receive-buffer pulse sets bits 7 and 15.
- R4: When an event sets a status bit in the same cycle that software clears it, the bit ends up set.
- R5: `irq` is high in the cycle after any write or event exactly when status AND interrupt mask is nonzero.
- R6: A write to the receive ring base (word 0x3C3) or the transmit ring base (word 0x3C4) loads both the base and the current pointer of that ring. The current pointers read back at words 0x3D3 (receive) and 0x3D2 (transmit) and drive `cur_rx_ptr` and `cur_tx_ptr`.
- R7: An engine pointer-advance request loads that ring's current pointer. A base write in the same cycle takes priority over the request. Software writes to the current-pointer words are ignored.
- R8: Word 0x008 always reads 0x1012. Writes to it are ignored.
- R9: A write to the bus-mode word (0x3C0) stores the data with bit 0 forced to 0.
- R10: `rx_enable` follows control bit 1. A write to word 0x3C1 raises `tx_poll` for exactly one cycle, stores nothing, and that word reads 0.
- R11: Other words below word 0x400 store and return written data. Words at or above 0x400 read 0 and ignore writes.
- R12: After reset, status, mask, control, pointers, `irq`, `tx_poll` and `rx_enable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | BYTE_AW | Byte address of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| ev_tx_done | input | 1 | Transmit frame completed pulse |
| ev_rx_done | input | 1 | Receive frame completed pulse |
| ev_rx_nobuf | input | 1 | Receive descriptor unavailable pulse |
| tx_ptr_upd | input | 1 | Transmit engine pointer-advance request |
| tx_ptr_val | input | DW | New transmit current pointer |
| rx_ptr_upd | input | 1 | Receive engine pointer-advance request |
| rx_ptr_val | input | DW | New receive current pointer |
| cur_tx_ptr | output | DW | Current transmit descriptor pointer |
| cur_rx_ptr | output | DW | Current receive descriptor pointer |
| rx_enable | output | 1 | Receive enabled (control bit 1) |
| tx_poll | output | 1 | One-cycle transmit poll demand |
| irq | output | 1 | Level interrupt |

## Verification
A vector table of writes and read-backs covers every special word and a plain RAM word. This separates pass-through storage from the masked, constant, aliased and side-effect words, and it shows an out-of-window write leaving the word it would alias untouched. Directed sequences then pulse each event type against masks that include or exclude the affected bit. This tells an enabled bit apart from the summary bits it drags along, and a clear from a same-cycle set. Pointer tests issue an engine request alone, together with a base write, and against a software write to the read-only current word. Together these tell the priority order apart from either source alone.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  // word indices inside the register window
  localparam int W_VERSION = 'h008;
  localparam int W_BUSMODE = 'h3C0;
  localparam int W_POLL    = 'h3C1;
  localparam int W_RXBASE  = 'h3C3;
  localparam int W_TXBASE  = 'h3C4;
  localparam int W_STATUS  = 'h3C5;
  localparam int W_CTRL    = 'h3C6;
  localparam int W_IMASK   = 'h3C7;
  localparam int W_CURTX   = 'h3D2;
  localparam int W_CURRX   = 'h3D3;

  localparam logic [31:0] VERSION_VAL = 32'h0000_1012;

  // status bit positions
  localparam int SB_TXDONE = 0;
  localparam int SB_RXDONE = 6;
  localparam int SB_RXNOBUF = 7;
  localparam int SB_ABNORMAL = 15;
  localparam int SB_NORMAL = 16;

  localparam int CB_RXEN = 1;

  // ring channel indices
  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/dmareg_store.sv
module dmareg_store #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dmareg_status.sv
module dmareg_status
  import dmareg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  input  logic          mask_wr,
  input  logic [DW-1:0] mask_wdata,
  input  logic          ev_tx_done,
  input  logic          ev_rx_done,
  input  logic          ev_rx_nobuf,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_q
);
  logic [DW-1:0] set_bits;
  logic [DW-1:0] status_n;
  logic [DW-1:0] mask_n;

  always_comb begin
    set_bits = '0;
    if (ev_tx_done) begin
      set_bits[SB_TXDONE] = 1'b1;
      set_bits[SB_NORMAL] = 1'b1;
    end
    if (ev_rx_done) begin
      set_bits[SB_RXDONE] = 1'b1;
      set_bits[SB_NORMAL] = 1'b1;
    end
    if (ev_rx_nobuf) begin
      set_bits[SB_RXNOBUF]  = 1'b1;
      set_bits[SB_ABNORMAL] = 1'b1;
    end
  end

  // clear first, then OR in the events so a coincident set survives
  assign status_n = (status_q & ~(clr_en ? clr_mask : '0)) | set_bits;
  assign mask_n   = mask_wr ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      irq_q    <= |(status_n & mask_n);
    end
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_en && set_bits == '0) |=> status_q == ($past(status_q) & ~$past(clr_mask)));
  p_set_tx_r3: assert property (@(posedge clk) disable iff (rst)
    ev_tx_done |=> (status_q[SB_TXDONE] && status_q[SB_NORMAL]));
  p_set_nobuf_r3: assert property (@(posedge clk) disable iff (rst)
    ev_rx_nobuf |=> (status_q[SB_RXNOBUF] && status_q[SB_ABNORMAL]));
  p_setwins_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_done && clr_en && clr_mask[SB_RXDONE]) |=> status_q[SB_RXDONE]);
  p_irq_high_r5: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q) != '0) |-> irq_q);
  p_irq_low_r5: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q) == '0) |-> !irq_q);
endmodule

// File: rtl/dmareg_ptr.sv
module dmareg_ptr #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_wr,
  input  logic [DW-1:0] wdata,
  input  logic          upd,
  input  logic [DW-1:0] upd_val,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] cur_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (base_wr) begin
      base_q <= wdata;
      cur_q  <= wdata;
    end else if (upd) begin
      cur_q  <= upd_val;
    end
  end

  p_base_load_r6: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> (cur_q == $past(wdata) && base_q == $past(wdata)));
  p_engine_upd_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && !base_wr) |=> (cur_q == $past(upd_val) && $stable(base_q)));
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int DW           = 32,
  parameter int BYTE_AW      = 13,
  parameter int WINDOW_WORDS = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BYTE_AW-1:0] reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               reg_rvalid,
  input  logic               ev_tx_done,
  input  logic               ev_rx_done,
  input  logic               ev_rx_nobuf,
  input  logic               tx_ptr_upd,
  input  logic [DW-1:0]      tx_ptr_val,
  input  logic               rx_ptr_upd,
  input  logic [DW-1:0]      rx_ptr_val,
  output logic [DW-1:0]      cur_tx_ptr,
  output logic [DW-1:0]      cur_rx_ptr,
  output logic               rx_enable,
  output logic               tx_poll,
  output logic               irq
);
  localparam int WIDX = BYTE_AW - 2;
  localparam int RAW  = $clog2(WINDOW_WORDS);

  logic [WIDX-1:0] word;
  logic [RAW-1:0]  widx;
  logic            in_win;
  logic            unused_lo;

  assign word      = reg_addr[BYTE_AW-1:2];
  assign widx      = word[RAW-1:0];
  assign in_win    = (word >> RAW) == '0;
  assign unused_lo = ^reg_addr[1:0];

  // decode of the special words
  logic hit_version, hit_bus, hit_poll, hit_rxbase, hit_txbase;
  logic hit_status, hit_ctrl, hit_mask, hit_curtx, hit_currx, hit_special;

  assign hit_version = in_win && widx == RAW'(W_VERSION);
  assign hit_bus     = in_win && widx == RAW'(W_BUSMODE);
  assign hit_poll    = in_win && widx == RAW'(W_POLL);
  assign hit_rxbase  = in_win && widx == RAW'(W_RXBASE);
  assign hit_txbase  = in_win && widx == RAW'(W_TXBASE);
  assign hit_status  = in_win && widx == RAW'(W_STATUS);
  assign hit_ctrl    = in_win && widx == RAW'(W_CTRL);
  assign hit_mask    = in_win && widx == RAW'(W_IMASK);
  assign hit_curtx   = in_win && widx == RAW'(W_CURTX);
  assign hit_currx   = in_win && widx == RAW'(W_CURRX);
  assign hit_special = hit_version | hit_bus | hit_poll | hit_rxbase | hit_txbase
                     | hit_status | hit_ctrl | hit_mask | hit_curtx | hit_currx;

  // status, mask and interrupt
  logic [DW-1:0] status_q, mask_q;

  dmareg_status #(.DW(DW)) u_status (
    .clk        (clk),
    .rst        (rst),
    .clr_en     (reg_wr && hit_status),
    .clr_mask   (reg_wdata),
    .mask_wr    (reg_wr && hit_mask),
    .mask_wdata (reg_wdata),
    .ev_tx_done (ev_tx_done),
    .ev_rx_done (ev_rx_done),
    .ev_rx_nobuf(ev_rx_nobuf),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .irq_q      (irq)
  );

  // descriptor ring pointers, one instance per channel
  logic [NUM_CH-1:0] ch_base_wr, ch_upd;
  logic [DW-1:0]     ch_upd_val [NUM_CH];
  logic [DW-1:0]     ch_base    [NUM_CH];
  logic [DW-1:0]     ch_cur     [NUM_CH];

  assign ch_base_wr[CH_TX] = reg_wr && hit_txbase;
  assign ch_base_wr[CH_RX] = reg_wr && hit_rxbase;
  assign ch_upd[CH_TX]     = tx_ptr_upd;
  assign ch_upd[CH_RX]     = rx_ptr_upd;
  assign ch_upd_val[CH_TX] = tx_ptr_val;
  assign ch_upd_val[CH_RX] = rx_ptr_val;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ring
    dmareg_ptr #(.DW(DW)) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .base_wr(ch_base_wr[c]),
      .wdata  (reg_wdata),
      .upd    (ch_upd[c]),
      .upd_val(ch_upd_val[c]),
      .base_q (ch_base[c]),
      .cur_q  (ch_cur[c])
    );
  end

  assign cur_tx_ptr = ch_cur[CH_TX];
  assign cur_rx_ptr = ch_cur[CH_RX];

  // control, bus mode and poll pulse
  logic [DW-1:0] ctrl_q, bus_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      bus_q   <= '0;
      tx_poll <= 1'b0;
    end else begin
      if (reg_wr && hit_ctrl) ctrl_q <= reg_wdata;
      if (reg_wr && hit_bus)  bus_q  <= {reg_wdata[DW-1:1], 1'b0};
      tx_poll <= reg_wr && hit_poll;
    end
  end

  assign rx_enable = ctrl_q[CB_RXEN];

  // generic word storage
  logic [DW-1:0] ram_q;

  dmareg_store #(.DEPTH(WINDOW_WORDS), .DW(DW)) u_store (
    .clk  (clk),
    .we   (reg_wr && in_win && !hit_special),
    .waddr(widx),
    .wdata(reg_wdata),
    .re   (reg_rd),
    .raddr(widx),
    .rdata(ram_q)
  );

  // read path: special words captured in flops, plain words from the store
  logic [DW-1:0] sel_val;
  logic [DW-1:0] spec_q;
  logic          use_ram_q;

  always_comb begin
    sel_val = '0;
    if (hit_version)     sel_val = DW'(VERSION_VAL);
    else if (hit_bus)    sel_val = bus_q;
    else if (hit_rxbase) sel_val = ch_base[CH_RX];
    else if (hit_txbase) sel_val = ch_base[CH_TX];
    else if (hit_status) sel_val = status_q;
    else if (hit_ctrl)   sel_val = ctrl_q;
    else if (hit_mask)   sel_val = mask_q;
    else if (hit_curtx)  sel_val = ch_cur[CH_TX];
    else if (hit_currx)  sel_val = ch_cur[CH_RX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      use_ram_q  <= 1'b0;
      spec_q     <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        use_ram_q <= in_win && !hit_special;
        spec_q    <= sel_val;
      end
    end
  end

  assign reg_rdata = use_ram_q ? ram_q : spec_q;

  p_poll_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    tx_poll |-> $past(reg_wr && hit_poll));
  p_bus_bit0_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rvalid && $past(reg_rd && hit_bus)) |-> !reg_rdata[0]);
  p_outside_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_rvalid && $past(reg_rd && !in_win)) |-> reg_rdata == '0);
endmodule

// File: tb/tb_dmareg_bank.sv
module tb_dmareg_bank;
  localparam int DW = 32;
  localparam int BAW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BAW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic reg_rvalid;
  logic ev_tx_done = 1'b0, ev_rx_done = 1'b0, ev_rx_nobuf = 1'b0;
  logic tx_ptr_upd = 1'b0, rx_ptr_upd = 1'b0;
  logic [DW-1:0] tx_ptr_val = '0, rx_ptr_val = '0;
  logic [DW-1:0] cur_tx_ptr, cur_rx_ptr;
  logic rx_enable, tx_poll, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmareg_bank dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_rx_nobuf(ev_rx_nobuf),
    .tx_ptr_upd(tx_ptr_upd), .tx_ptr_val(tx_ptr_val),
    .rx_ptr_upd(rx_ptr_upd), .rx_ptr_val(rx_ptr_val),
    .cur_tx_ptr(cur_tx_ptr), .cur_rx_ptr(cur_rx_ptr),
    .rx_enable(rx_enable), .tx_poll(tx_poll), .irq(irq)
  );

  // byte addresses
  localparam logic [12:0] A_VER = 13'h020, A_BUS = 13'hF00, A_POLL = 13'hF04;
  localparam logic [12:0] A_RXB = 13'hF0C, A_TXB = 13'hF10, A_STAT = 13'hF14;
  localparam logic [12:0] A_CTRL = 13'hF18, A_MASK = 13'hF1C;
  localparam logic [12:0] A_CTX = 13'hF48, A_CRX = 13'hF4C;

  // {read, req, byte addr, wdata, expected}
  localparam int NV = 22;
  localparam logic [81:0] VEC [NV] = '{
    {1'b1, 4'd2,  A_STAT, 32'h0, 32'h0},               // R2 clean status
    {1'b0, 4'd9,  A_BUS, 32'hFFFF_FFFF, 32'h0},        // R9
    {1'b1, 4'd9,  A_BUS, 32'h0, 32'hFFFF_FFFE},
    {1'b0, 4'd8,  A_VER, 32'h0000_DEAD, 32'h0},        // R8
    {1'b1, 4'd8,  A_VER, 32'h0, 32'h0000_1012},
    {1'b0, 4'd6,  A_RXB, 32'h1000_0000, 32'h0},        // R6
    {1'b1, 4'd6,  A_RXB, 32'h0, 32'h1000_0000},
    {1'b1, 4'd6,  A_CRX, 32'h0, 32'h1000_0000},
    {1'b0, 4'd6,  A_TXB, 32'h2000_0040, 32'h0},
    {1'b1, 4'd6,  A_CTX, 32'h0, 32'h2000_0040},
    {1'b0, 4'd1,  A_CTRL, 32'h0000_0002, 32'h0},       // R1
    {1'b1, 4'd1,  A_CTRL, 32'h0, 32'h0000_0002},
    {1'b0, 4'd1,  A_MASK, 32'h0000_0041, 32'h0},
    {1'b1, 4'd1,  A_MASK, 32'h0, 32'h0000_0041},
    {1'b0, 4'd11, 13'h040, 32'hA5A5_0001, 32'h0},      // R11
    {1'b1, 4'd11, 13'h040, 32'h0, 32'hA5A5_0001},
    {1'b0, 4'd11, 13'hFFC, 32'h1234_5678, 32'h0},
    {1'b1, 4'd11, 13'hFFC, 32'h0, 32'h1234_5678},
    {1'b0, 4'd11, 13'h1040, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 4'd11, 13'h1040, 32'h0, 32'h0},
    {1'b1, 4'd11, 13'h040, 32'h0, 32'hA5A5_0001},
    {1'b1, 4'd10, A_POLL, 32'h0, 32'h0}                // R10
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [BAW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [BAW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rvalid ? reg_rdata : 32'hBAD0_BAD0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 irq", {31'b0, irq}, 32'h0);
    check("R12 rx_enable", {31'b0, rx_enable}, 32'h0);
    check("R12 tx_poll", {31'b0, tx_poll}, 32'h0);
    check("R12 cur_tx_ptr", cur_tx_ptr, 32'h0);
    check("R12 cur_rx_ptr", cur_rx_ptr, 32'h0);
    do_read(A_MASK, rd); check("R12 mask", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][81]) begin
        do_read(VEC[i][76:64], rd);
        check($sformatf("R%0d vector %0d", VEC[i][80:77], i), rd, VEC[i][31:0]);
      end else begin
        do_write(VEC[i][76:64], VEC[i][63:32]);
      end
    end
    check("R6 cur_rx_ptr port", cur_rx_ptr, 32'h1000_0000);
    check("R6 cur_tx_ptr port", cur_tx_ptr, 32'h2000_0040);
    check("R10 rx_enable", {31'b0, rx_enable}, 32'h1);

    // events, mask 0x41 active
    @(negedge clk); ev_tx_done = 1'b1; @(negedge clk); ev_tx_done = 1'b0;
    check("R5 irq on tx done", {31'b0, irq}, 32'h1);
    do_read(A_STAT, rd); check("R3 tx done bits", rd, 32'h0001_0001);
    do_write(A_STAT, 32'h0000_0001);
    check("R5 irq after clear", {31'b0, irq}, 32'h0);
    do_read(A_STAT, rd); check("R2 partial clear", rd, 32'h0001_0000);
    @(negedge clk); ev_rx_nobuf = 1'b1; @(negedge clk); ev_rx_nobuf = 1'b0;
    check("R5 masked event no irq", {31'b0, irq}, 32'h0);
    do_read(A_STAT, rd); check("R3 nobuf bits", rd, 32'h0001_8080);
    // R4 set against clear in one cycle
    @(negedge clk);
    reg_addr = A_STAT; reg_wdata = 32'h0000_0040; reg_wr = 1'b1; ev_rx_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_rx_done = 1'b0;
    check("R4 irq", {31'b0, irq}, 32'h1);
    do_read(A_STAT, rd); check("R4 set wins", rd, 32'h0001_80C0);
    do_write(A_MASK, 32'h0);
    check("R5 irq after mask off", {31'b0, irq}, 32'h0);
    do_write(A_MASK, 32'h0000_0080);
    check("R5 irq after mask on", {31'b0, irq}, 32'h1);
    do_write(A_STAT, 32'hFFFF_FFFF);
    do_read(A_STAT, rd); check("R2 full clear", rd, 32'h0);
    check("R5 irq idle", {31'b0, irq}, 32'h0);

    // R7 pointer requests
    @(negedge clk); tx_ptr_upd = 1'b1; tx_ptr_val = 32'h0000_3000;
    @(negedge clk); tx_ptr_upd = 1'b0;
    check("R7 tx advance", cur_tx_ptr, 32'h0000_3000);
    do_read(A_TXB, rd); check("R7 base kept", rd, 32'h2000_0040);
    @(negedge clk);
    rx_ptr_upd = 1'b1; rx_ptr_val = 32'h0000_5555;
    reg_addr = A_RXB; reg_wdata = 32'h0000_7000; reg_wr = 1'b1;
    @(negedge clk); rx_ptr_upd = 1'b0; reg_wr = 1'b0;
    check("R7 base write wins", cur_rx_ptr, 32'h0000_7000);
    do_write(A_CTX, 32'h0000_0BAD);
    check("R7 cur word read-only", cur_tx_ptr, 32'h0000_3000);

    // R10 poll pulse
    do_write(A_POLL, 32'hFFFF_FFFF);
    check("R10 poll high", {31'b0, tx_poll}, 32'h1);
    @(negedge clk);
    check("R10 poll one cycle", {31'b0, tx_poll}, 32'h0);
    do_read(A_POLL, rd); check("R10 poll not stored", rd, 32'h0);
    do_write(A_CTRL, 32'h0);
    check("R10 rx disabled", {31'b0, rx_enable}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule